// File: doc/BRIEF.md
# Home-Node Line Directory Controller

This block sits at one home node of a shared-address multiprocessor in which every node owns a contiguous slice of physical memory. For each memory line in its slice it keeps a one-holder record. The record holds a flag saying whether some cache has the line, and the number of the node that has it. Remote nodes send line requests or eviction notices. For a line nobody caches, the controller reads the line from local memory and returns it to the requester. For a line that is already cached, it sends a forward message to the current holder so that the holder passes the line on.

A line is cached at no more than one node. A second requester therefore takes the line over: the record keeps its flag set and now names the new node. A request arrives on a valid/ready channel, and the controller handles one at a time. It raises ready again only after its outgoing message has been taken. A request that carries another node's number in its home field is answered with an error and changes no record. The line-index width is a parameter, so a bench can use a small record array.

Top module: `home_dir_ctrl`

## Requirements
- R1: The request address is read as {home node (NODE_W bits, top), line index (IDX_W bits), byte offset (6 bits, bottom)}. The offset has no effect on any result.
- R2: After reset every line's record is empty. `req_ready` is 1, and `msg_valid` and `mem_rd_en` are 0.
- R3: A fetch (`req_evict`=0) to an empty line raises `mem_rd_en` with that line index in the cycle after acceptance. After the second clock edge following acceptance, the controller presents a message with `msg_kind`=0 (data). This message has `msg_dest` = `msg_req` = requester and carries the memory word read.
- R4: After a fetch, the line's record is set and names the requester. The next fetch of that line by any node is forwarded to it.
- R5: A fetch to a cached line reads no memory. After the first clock edge following acceptance, the controller presents `msg_kind`=1 (forward) with `msg_dest` = recorded holder, `msg_req` = requester and `msg_data`=0. The record then names the requester.
- R6: An evict (`req_evict`=1) from the recorded holder empties the record. It produces no message, and `req_ready` returns after one clock edge.
- R7: An evict from any node other than the recorded holder, or to an empty line, leaves the record unchanged and produces no message.
- R8: A request whose home field differs from parameter HOME_ID gets `msg_kind`=2 (error), sent to the requester one edge after acceptance with `msg_data`=0. It reads no memory and leaves the record unchanged.
- R9: `req_ready` is 0 from acceptance until the outgoing message is accepted, or until an evict ends. While `msg_valid` is 1 and `msg_ready` is 0, all message fields hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_evict | input | 1 | 1 = evict/write-back notice, 0 = line fetch |
| req_src | input | NODE_W | Requesting node number |
| req_addr | input | NODE_W+IDX_W+6 | Physical address of the line |
| mem_rd_en | output | 1 | Local memory read strobe; data returns one cycle later |
| mem_rd_idx | output | IDX_W | Line index to read |
| mem_rd_data | input | LINE_W | Line data from local memory |
| msg_valid | output | 1 | Outgoing message present |
| msg_ready | input | 1 | Network takes the message |
| msg_kind | output | 2 | 0 data, 1 forward, 2 error |
| msg_dest | output | NODE_W | Node the message is sent to |
| msg_req | output | NODE_W | Original requester |
| msg_idx | output | IDX_W | Line index concerned |
| msg_data | output | LINE_W | Line data (data messages), else 0 |

## Verification
A wrong record does not show at once. It surfaces on the next fetch of the same line, as a data message where a forward was due, a forward to the wrong node, or a memory read that should not happen. For this reason the bench always follows an update with a fetch of the same line. A broken sequencer shows within one or two cycles of acceptance: the message appears on the wrong edge, `req_ready` returns too early, or a stalled message changes. A behavioural record model in the bench predicts each of these cycle by cycle.

// File: rtl/hdc_pkg.sv
// Package: shared encodings for the home-node line directory controller.
// Assumes: message kind codes are decoded by the network interface downstream.
package hdc_pkg;
    localparam int OFF_W = 6;

    typedef enum logic [1:0] {
        MSG_DATA = 2'd0,
        MSG_FWD  = 2'd1,
        MSG_ERR  = 2'd2
    } msg_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOK = 2'd1,
        ST_MEM  = 2'd2,
        ST_SEND = 2'd3
    } seq_state_e;
endpackage

// File: rtl/hdc_addr_decode.sv
// Module: splits a physical address into home node and line index fields and
// flags whether the home field names this node.
// Assumes: address layout {node, index, 6-bit byte offset}; the offset is unused.
module hdc_addr_decode #(
    parameter int NODE_W  = 8,
    parameter int IDX_W   = 18,
    parameter int HOME_ID = 36,
    localparam int ADDR_W = NODE_W + IDX_W + hdc_pkg::OFF_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  line_idx,
    output logic              home_ok
);
    localparam int OFF_W = hdc_pkg::OFF_W;

    logic [NODE_W-1:0] node_field;
    logic              unused_off;

    // Field extraction and home-node comparison.
    always_comb begin
        node_field = addr[ADDR_W-1 -: NODE_W];
        line_idx   = addr[OFF_W +: IDX_W];
        home_ok    = (node_field == NODE_W'(HOME_ID));
        unused_off = ^addr[OFF_W-1:0];
    end
endmodule

// File: rtl/hdc_dir_array.sv
// Module: one-holder directory records, one per line of the home slice.
// Assumes: single combinational read port, single write port, writes take
// effect at the clock edge; reset empties every record.
module hdc_dir_array #(
    parameter int NODE_W = 8,
    parameter int IDX_W  = 18,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_present,
    output logic [NODE_W-1:0] rd_holder,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_present,
    input  logic [NODE_W-1:0] wr_holder
);
    logic              pres [DEPTH];
    logic [NODE_W-1:0] hold [DEPTH];

    // Record storage: cleared on reset, single-entry update otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                pres[i] <= 1'b0;
                hold[i] <= '0;
            end
        end else if (wr_en) begin
            pres[wr_idx] <= wr_present;
            hold[wr_idx] <= wr_holder;
        end
    end

    // Lookup port.
    always_comb begin
        rd_present = pres[rd_idx];
        rd_holder  = hold[rd_idx];
    end

    // R2: the first lookup after reset sees an empty record.
    a_r2_empty_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !rd_present);
endmodule

// File: rtl/hdc_sequencer.sv
// Module: request sequencer. Takes one request, looks up its record, reads
// memory or forwards, updates the record and holds the reply until taken.
// Assumes: memory returns data the cycle after mem_rd_en; the record read
// port is combinational.
module hdc_sequencer #(
    parameter int NODE_W = 8,
    parameter int IDX_W  = 18,
    parameter int LINE_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_evict,
    input  logic [NODE_W-1:0] req_src,
    input  logic [IDX_W-1:0]  dec_idx,
    input  logic              dec_home_ok,
    output logic [IDX_W-1:0]  dir_rd_idx,
    input  logic              dir_rd_present,
    input  logic [NODE_W-1:0] dir_rd_holder,
    output logic              dir_we,
    output logic [IDX_W-1:0]  dir_wr_idx,
    output logic              dir_wr_present,
    output logic [NODE_W-1:0] dir_wr_holder,
    output logic              mem_rd_en,
    output logic [IDX_W-1:0]  mem_rd_idx,
    input  logic [LINE_W-1:0] mem_rd_data,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [1:0]        msg_kind,
    output logic [NODE_W-1:0] msg_dest,
    output logic [NODE_W-1:0] msg_req,
    output logic [IDX_W-1:0]  msg_idx,
    output logic [LINE_W-1:0] msg_data
);
    import hdc_pkg::*;

    seq_state_e        state, state_nx;
    logic              r_evict, r_home_ok;
    logic [NODE_W-1:0] r_src;
    logic [IDX_W-1:0]  r_idx;
    logic              load_msg;
    msg_kind_e         nx_kind;
    logic [NODE_W-1:0] nx_dest;
    logic [LINE_W-1:0] nx_data;

    assign req_ready  = (state == ST_IDLE);
    assign msg_valid  = (state == ST_SEND);
    assign dir_rd_idx = r_idx;
    assign dir_wr_idx = r_idx;
    assign mem_rd_idx = r_idx;

    // Next-state, record update, memory strobe and reply selection.
    always_comb begin
        state_nx       = state;
        dir_we         = 1'b0;
        dir_wr_present = 1'b1;
        dir_wr_holder  = r_src;
        mem_rd_en      = 1'b0;
        load_msg       = 1'b0;
        nx_kind        = MSG_ERR;
        nx_dest        = r_src;
        nx_data        = '0;
        unique case (state)
            ST_IDLE: if (req_valid) state_nx = ST_LOOK;
            ST_LOOK: begin
                if (!r_home_ok) begin
                    load_msg = 1'b1;
                    state_nx = ST_SEND;
                end else if (r_evict) begin
                    if (dir_rd_present && dir_rd_holder == r_src) begin
                        dir_we         = 1'b1;
                        dir_wr_present = 1'b0;
                    end
                    state_nx = ST_IDLE;
                end else if (dir_rd_present) begin
                    dir_we   = 1'b1;
                    load_msg = 1'b1;
                    nx_kind  = MSG_FWD;
                    nx_dest  = dir_rd_holder;
                    state_nx = ST_SEND;
                end else begin
                    mem_rd_en = 1'b1;
                    state_nx  = ST_MEM;
                end
            end
            ST_MEM: begin
                dir_we   = 1'b1;
                load_msg = 1'b1;
                nx_kind  = MSG_DATA;
                nx_data  = mem_rd_data;
                state_nx = ST_SEND;
            end
            ST_SEND: if (msg_ready) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Request capture on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_evict   <= 1'b0;
            r_home_ok <= 1'b0;
            r_src     <= '0;
            r_idx     <= '0;
        end else if (req_valid && req_ready) begin
            r_evict   <= req_evict;
            r_home_ok <= dec_home_ok;
            r_src     <= req_src;
            r_idx     <= dec_idx;
        end
    end

    // Outgoing message register, loaded once per request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msg_kind <= 2'd0;
            msg_dest <= '0;
            msg_req  <= '0;
            msg_idx  <= '0;
            msg_data <= '0;
        end else if (load_msg) begin
            msg_kind <= nx_kind;
            msg_dest <= nx_dest;
            msg_req  <= r_src;
            msg_idx  <= r_idx;
            msg_data <= nx_data;
        end
    end

    // R9: a stalled message keeps every field.
    a_r9_hold_msg: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_kind) && $stable(msg_dest)
            && $stable(msg_req) && $stable(msg_idx) && $stable(msg_data)));
    // R9: accepting a request closes the request channel.
    a_r9_single_request: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    // R3: a memory read yields a data message two edges later.
    a_r3_mem_to_data: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> ##1 (msg_valid && msg_kind == 2'd0));
    // R5: no memory read while a forward is outstanding.
    a_r5_fwd_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == 2'd1) |-> (!mem_rd_en && msg_data == '0));
    // R8: errors go back to the requester and carry no data.
    a_r8_err_to_src: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == 2'd2) |-> (msg_dest == msg_req && msg_data == '0));
endmodule

// File: rtl/home_dir_ctrl.sv
// Module: top of the home-node line directory controller: address decode,
// record array and request sequencer.
// Assumes: one request in flight; single-holder lines; HOME_ID is this node.
module home_dir_ctrl #(
    parameter int NODE_W  = 8,
    parameter int IDX_W   = 8,
    parameter int LINE_W  = 64,
    parameter int HOME_ID = 36,
    localparam int ADDR_W = NODE_W + IDX_W + hdc_pkg::OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_evict,
    input  logic [NODE_W-1:0] req_src,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              mem_rd_en,
    output logic [IDX_W-1:0]  mem_rd_idx,
    input  logic [LINE_W-1:0] mem_rd_data,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [1:0]        msg_kind,
    output logic [NODE_W-1:0] msg_dest,
    output logic [NODE_W-1:0] msg_req,
    output logic [IDX_W-1:0]  msg_idx,
    output logic [LINE_W-1:0] msg_data
);
    logic [IDX_W-1:0]  dec_idx, rd_idx, wr_idx;
    logic              dec_home_ok, rd_present, we, wr_present;
    logic [NODE_W-1:0] rd_holder, wr_holder;

    hdc_addr_decode #(.NODE_W(NODE_W), .IDX_W(IDX_W), .HOME_ID(HOME_ID)) u_dec (
        .addr(req_addr), .line_idx(dec_idx), .home_ok(dec_home_ok));

    hdc_dir_array #(.NODE_W(NODE_W), .IDX_W(IDX_W)) u_dir (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(rd_idx), .rd_present(rd_present), .rd_holder(rd_holder),
        .wr_en(we), .wr_idx(wr_idx), .wr_present(wr_present), .wr_holder(wr_holder));

    hdc_sequencer #(.NODE_W(NODE_W), .IDX_W(IDX_W), .LINE_W(LINE_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_evict(req_evict),
        .req_src(req_src), .dec_idx(dec_idx), .dec_home_ok(dec_home_ok),
        .dir_rd_idx(rd_idx), .dir_rd_present(rd_present), .dir_rd_holder(rd_holder),
        .dir_we(we), .dir_wr_idx(wr_idx), .dir_wr_present(wr_present),
        .dir_wr_holder(wr_holder),
        .mem_rd_en(mem_rd_en), .mem_rd_idx(mem_rd_idx), .mem_rd_data(mem_rd_data),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
        .msg_dest(msg_dest), .msg_req(msg_req), .msg_idx(msg_idx), .msg_data(msg_data));
endmodule

// File: tb/home_dir_ctrl_test.sv
module home_dir_ctrl_test;
    localparam int NODE_W = 8;
    localparam int IDX_W  = 4;
    localparam int LINE_W = 32;
    localparam int HOME   = 36;
    localparam int ADDR_W = NODE_W + IDX_W + 6;
    localparam int NL     = 1 << IDX_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_evict = 1'b0, msg_ready = 1'b0;
    logic [NODE_W-1:0] req_src = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic req_ready, mem_rd_en, msg_valid;
    logic [IDX_W-1:0] mem_rd_idx, msg_idx;
    logic [LINE_W-1:0] mem_rd_data = '0, msg_data;
    logic [1:0] msg_kind;
    logic [NODE_W-1:0] msg_dest, msg_req;

    int checks = 0, errors = 0, cycles = 0;
    bit m_pres [NL];
    int m_hold [NL];

    home_dir_ctrl #(.NODE_W(NODE_W), .IDX_W(IDX_W), .LINE_W(LINE_W), .HOME_ID(HOME)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_evict(req_evict), .req_src(req_src), .req_addr(req_addr),
        .mem_rd_en(mem_rd_en), .mem_rd_idx(mem_rd_idx), .mem_rd_data(mem_rd_data),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
        .msg_dest(msg_dest), .msg_req(msg_req), .msg_idx(msg_idx), .msg_data(msg_data));

    always #4 clk = ~clk;

    // Local memory model: one-cycle read latency, content from the index.
    always @(posedge clk) if (mem_rd_en) mem_rd_data <= 32'hC0DE_0000 | 32'(mem_rd_idx);

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL R9 watchdog expired: actual hung, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // One request through the model; called at a negedge with the block idle.
    task automatic run(input bit ev, input int src, input int node, input int idx,
                       input int off, input int stall, input string rq);
        bit ok = (node == HOME);
        int kind = 2, dest = src, lat = 1;
        longint data = 0;
        bit none = 1'b0;
        if (!ok) begin kind = 2; lat = 1; end
        else if (ev) none = 1'b1;
        else if (m_pres[idx]) begin kind = 1; dest = m_hold[idx]; lat = 1; end
        else begin kind = 0; lat = 2; data = 64'hC0DE_0000 | idx; end

        chk(req_ready == 1'b1, rq, "ready before request", req_ready, 1);
        req_valid = 1'b1; req_evict = ev; req_src = NODE_W'(src);
        req_addr = {NODE_W'(node), IDX_W'(idx), 6'(off)};
        tick();
        req_valid = 1'b0;
        chk(req_ready == 1'b0, rq, "ready while busy (R9)", req_ready, 0);
        chk(mem_rd_en == (ok && !ev && kind == 0), rq, "memory strobe", mem_rd_en,
            (ok && !ev && kind == 0));
        if (mem_rd_en) chk(mem_rd_idx == IDX_W'(idx), rq, "memory index", mem_rd_idx, idx);
        chk(msg_valid == 1'b0, rq, "early message", msg_valid, 0);
        if (none) begin
            tick();
            chk(msg_valid == 1'b0, rq, "evict message", msg_valid, 0);
            chk(req_ready == 1'b1, rq, "ready after evict", req_ready, 1);
            if (m_pres[idx] && m_hold[idx] == src) m_pres[idx] = 1'b0;
            return;
        end
        if (lat == 2) begin
            tick();
            chk(msg_valid == 1'b0, rq, "data latency", msg_valid, 0);
        end
        tick();
        for (int s = 0; s <= stall; s++) begin
            chk(msg_valid == 1'b1, rq, "message valid", msg_valid, 1);
            chk(msg_kind == 2'(kind), rq, "message kind", msg_kind, kind);
            chk(msg_dest == NODE_W'(dest), rq, "message dest", msg_dest, dest);
            chk(msg_req == NODE_W'(src), rq, "message requester", msg_req, src);
            chk(msg_idx == IDX_W'(idx), rq, "message index", msg_idx, idx);
            chk(msg_data == LINE_W'(data), rq, "message data", msg_data, data);
            if (s < stall) tick();
        end
        msg_ready = 1'b1;
        tick();
        msg_ready = 1'b0;
        chk(msg_valid == 1'b0, rq, "message drop (R9)", msg_valid, 0);
        chk(req_ready == 1'b1, rq, "ready after reply (R9)", req_ready, 1);
        if (ok) begin m_pres[idx] = 1'b1; m_hold[idx] = src; end
    endtask

    initial begin
        for (int i = 0; i < NL; i++) begin m_pres[i] = 1'b0; m_hold[i] = 0; end
        @(negedge clk); @(negedge clk); @(negedge clk);
        chk(req_ready == 1'b1, "R2", "reset ready", req_ready, 1);
        chk(msg_valid == 1'b0, "R2", "reset msg_valid", msg_valid, 0);
        chk(mem_rd_en == 1'b0, "R2", "reset mem_rd_en", mem_rd_en, 0);
        rst_n = 1'b1;
        @(negedge clk);

        run(0, 20, HOME, 4, 8, 0, "R3");     // empty line -> data; R1 offset 8
        run(0, 82, HOME, 4, 0, 0, "R4");     // now forwarded to 20
        run(0, 20, HOME, 4, 63, 2, "R5");    // forward to 82, stalled (R9)
        run(1, 82, HOME, 4, 0, 0, "R7");     // not holder: ignored
        run(0, 7, HOME, 4, 0, 0, "R7");      // still forwards to 20
        run(1, 7, HOME, 4, 0, 0, "R6");      // holder evicts
        run(0, 9, HOME, 4, 0, 0, "R6");      // empty again -> data
        run(1, 9, HOME, 3, 0, 0, "R7");      // evict to empty line ignored
        run(0, 9, HOME, 3, 0, 0, "R7");      // line 3 still empty -> data
        run(0, 11, 37, 2, 0, 3, "R8");       // wrong home, stalled
        run(0, 11, HOME, 2, 0, 0, "R8");     // line 2 untouched -> data
        run(1, 9, 5, 4, 0, 0, "R8");         // wrong-home evict -> error
        run(0, 3, HOME, 4, 0, 0, "R8");      // holder 9 kept -> forward
        run(0, 1, HOME, NL - 1, 5, 0, "R1"); // top index
        run(0, 2, HOME, 0, 0, 0, "R1");      // index 0
        run(0, 1, HOME, 0, 0, 1, "R5");      // forward to 2

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule